// File: doc/BRIEF.md
# Adaptive Headroom Controller with LED Fault Detection

This block sits beside a bank of LED current sinks and decides, once per evaluation tick, whether the target voltage of the string supply converter should go up one step, go down one step or stay where it is. Each channel reports its cathode voltage through four comparator flags: below the low threshold, clearly above the low threshold (past a small band), above the mid threshold and above the high threshold. The controller keeps the lowest participating cathode sitting at the low threshold, which is the least supply voltage that still lets every sink regulate.

The same flags drive fault detection. A string that stays starved while the target is already at full scale is declared open. A string whose cathode sits above the high threshold while another string is inside the normal window (between the low and mid thresholds) is declared shorted. A faulted channel is switched off and leaves the regulation loop while the others keep running. Channels that were grounded at startup are never enabled and never take part. A fault-clear pulse wipes the fault flags, forces all sink enables off for its duration and leaves the target code untouched.

Top module: `hr_ctrl`

## Requirements
- R1: On an evaluation tick, if any participating channel has `below_low` set, `vtgt_code` rises by one LSB on the next clock edge, saturating at the all-ones code.
- R2: On an evaluation tick, if at least one channel participates and every participating channel has `above_band` set and none has `below_low`, `vtgt_code` falls by one LSB, saturating at zero.
- R3: On an evaluation tick where no participating channel is starved and at least one participating channel has neither `below_low` nor `above_band` (at the threshold), or no channel participates, `vtgt_code` keeps its value.
- R4: While `normal_en` is low, `gnd_mask` is captured each cycle; a channel whose captured mask bit is 1 has `ch_en` low and takes part neither in regulation nor in fault detection.
- R5: On a tick with `normal_en` high and `vtgt_code` at all-ones, each participating channel with `below_low` set gets its `open_flag` bit set; that channel's `ch_en` then goes low and it leaves the loop.
- R6: On a tick with `normal_en` high, a participating channel with `above_high` set gets its `short_flag` bit set if some other participating channel has `below_low` and `above_mid` both clear; it is then disabled and removed from the loop.
- R7: With `normal_en` low no fault flag is set; a fault on one channel leaves the enables and regulation of the other channels working.
- R8: After reset `vtgt_code` equals floor(MAX*INIT_PCT/100) with MAX the all-ones code (default 224 for 8 bits, 13 for 4 bits), all fault flags are 0 and `led_fault` is low.
- R9: While `fault_clr` is high, `ch_en` is all zero, `led_fault` is low, ticks do not move `vtgt_code`, and all fault flags are 0 from the next edge on; after release non-grounded channels are enabled again.
- R10: `vtgt_code` changes only on a clock edge where `eval_tick` was high, and then by exactly one LSB or not at all; `led_fault` is high exactly when any open or short flag is set and `fault_clr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| normal_en | input | 1 | High in the normal running state; enables fault detection, low lets the ground mask be captured |
| eval_tick | input | 1 | One-cycle evaluation strobe |
| fault_clr | input | 1 | Fault-clear pulse, held for its whole duration |
| gnd_mask | input | NUM_CH | 1 = channel found grounded at startup |
| below_low | input | NUM_CH | 1 = cathode below the low threshold |
| above_band | input | NUM_CH | 1 = cathode clearly above the low threshold |
| above_mid | input | NUM_CH | 1 = cathode above the mid threshold |
| above_high | input | NUM_CH | 1 = cathode above the high threshold |
| vtgt_code | output | CODE_W | Converter target-voltage code |
| ch_en | output | NUM_CH | Per-channel sink enable |
| open_flag | output | NUM_CH | Per-channel open-string flag |
| short_flag | output | NUM_CH | Per-channel shorted-string flag |
| led_fault | output | 1 | Any LED fault present |

## Verification
The bench builds the block with four channels and a 4-bit target code, so full scale is 15 and the start code is 13. With only fifteen steps both saturation ends are reached in a handful of ticks, which lets a complete sweep of all 81 three-state channel combinations and all 16 ground masks run in one pass while the expected code is tracked arithmetically. Open detection at full scale, short detection with and without a companion in the normal window, the gating by the normal state and the clear pulse are then driven as directed sequences on top of that small code range.

// File: rtl/hr_pkg.sv
package hr_pkg;

   typedef enum logic [1:0] {
      ADJ_HOLD = 2'd0,
      ADJ_UP   = 2'd1,
      ADJ_DOWN = 2'd2
   } adj_e;

   // Start code as a fraction of full scale, rounded down.
   function automatic int unsigned start_code(input int unsigned w, input int unsigned pct);
      int unsigned full;
      full = (1 << w) - 1;
      return (full * pct) / 100;
   endfunction

endpackage

// File: rtl/hr_part.sv
// Ground-mask capture and participation set.
module hr_part #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              normal_en,
   input  logic [NUM_CH-1:0] gnd_mask,
   input  logic [NUM_CH-1:0] open_q,
   input  logic [NUM_CH-1:0] short_q,
   output logic [NUM_CH-1:0] gnd_q,
   output logic [NUM_CH-1:0] part
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnd_q <= '0;
      end else if (!normal_en) begin
         gnd_q <= gnd_mask;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_part
      assign part[c] = ~gnd_q[c] & ~open_q[c] & ~short_q[c];
   end

endmodule

// File: rtl/hr_reg.sv
// Target-code regulator: vote across participating channels, step by one LSB.
module hr_reg
   import hr_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned INIT_PCT = 88
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_tick,
   input  logic              freeze,
   input  logic [NUM_CH-1:0] part,
   input  logic [NUM_CH-1:0] below_low,
   input  logic [NUM_CH-1:0] above_band,
   output logic [CODE_W-1:0] code_q
);

   localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(start_code(CODE_W, INIT_PCT));

   logic [NUM_CH-1:0] starved;
   logic [NUM_CH-1:0] roomy;
   adj_e              adj;
   logic [CODE_W-1:0] code_d;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_vote
      assign starved[c] = part[c] & below_low[c];
      // non-participants count as roomy so they never block a decrease
      assign roomy[c]   = ~part[c] | (above_band[c] & ~below_low[c]);
   end

   always_comb begin
      if (|starved) begin
         adj = ADJ_UP;
      end else if ((&roomy) && (|part)) begin
         adj = ADJ_DOWN;
      end else begin
         adj = ADJ_HOLD;
      end
   end

   always_comb begin
      code_d = code_q;
      unique case (adj)
         ADJ_UP:   if (code_q != CODE_MAX) code_d = code_q + 1'b1;
         ADJ_DOWN: if (code_q != '0)       code_d = code_q - 1'b1;
         default:  code_d = code_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_INIT;
      end else if (eval_tick && !freeze) begin
         code_q <= code_d;
      end
   end

endmodule

// File: rtl/hr_fault.sv
// Open and short detection, per channel sticky flags.
module hr_fault #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_tick,
   input  logic              normal_en,
   input  logic              clr,
   input  logic              code_full,
   input  logic [NUM_CH-1:0] part,
   input  logic [NUM_CH-1:0] below_low,
   input  logic [NUM_CH-1:0] above_mid,
   input  logic [NUM_CH-1:0] above_high,
   output logic [NUM_CH-1:0] open_q,
   output logic [NUM_CH-1:0] short_q
);

   logic              detect;
   logic [NUM_CH-1:0] in_window;

   assign detect = eval_tick & normal_en & ~clr;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_win
      assign in_window[c] = part[c] & ~below_low[c] & ~above_mid[c];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic              hit_open;
      logic              hit_short;
      logic [NUM_CH-1:0] peer_mask;

      always_comb begin
         peer_mask    = in_window;
         peer_mask[c] = 1'b0;
      end

      assign hit_open  = detect & code_full & part[c] & below_low[c];
      assign hit_short = detect & part[c] & above_high[c] & (|peer_mask);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[c]  <= 1'b0;
            short_q[c] <= 1'b0;
         end else if (clr) begin
            open_q[c]  <= 1'b0;
            short_q[c] <= 1'b0;
         end else begin
            if (hit_open)  open_q[c]  <= 1'b1;
            if (hit_short) short_q[c] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hr_ctrl.sv
// Adaptive headroom controller top.
module hr_ctrl #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned INIT_PCT = 88
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              normal_en,
   input  logic              eval_tick,
   input  logic              fault_clr,
   input  logic [NUM_CH-1:0] gnd_mask,
   input  logic [NUM_CH-1:0] below_low,
   input  logic [NUM_CH-1:0] above_band,
   input  logic [NUM_CH-1:0] above_mid,
   input  logic [NUM_CH-1:0] above_high,
   output logic [CODE_W-1:0] vtgt_code,
   output logic [NUM_CH-1:0] ch_en,
   output logic [NUM_CH-1:0] open_flag,
   output logic [NUM_CH-1:0] short_flag,
   output logic              led_fault
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("hr_ctrl: NUM_CH must be at least 2 for short detection");
   end
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_w
      $error("hr_ctrl: CODE_W must lie in 2..16");
   end
   if (INIT_PCT > 100) begin : g_bad_pct
      $error("hr_ctrl: INIT_PCT must not exceed 100");
   end

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   logic [NUM_CH-1:0] gnd_q;
   logic [NUM_CH-1:0] part;
   logic [NUM_CH-1:0] open_q;
   logic [NUM_CH-1:0] short_q;

   hr_part #(.NUM_CH(NUM_CH)) u_part (
      .clk       (clk),
      .rst_n     (rst_n),
      .normal_en (normal_en),
      .gnd_mask  (gnd_mask),
      .open_q    (open_q),
      .short_q   (short_q),
      .gnd_q     (gnd_q),
      .part      (part)
   );

   hr_reg #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .INIT_PCT(INIT_PCT)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval_tick  (eval_tick),
      .freeze     (fault_clr),
      .part       (part),
      .below_low  (below_low),
      .above_band (above_band),
      .code_q     (vtgt_code)
   );

   hr_fault #(.NUM_CH(NUM_CH)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval_tick  (eval_tick),
      .normal_en  (normal_en),
      .clr        (fault_clr),
      .code_full  (vtgt_code == CODE_MAX),
      .part       (part),
      .below_low  (below_low),
      .above_mid  (above_mid),
      .above_high (above_high),
      .open_q     (open_q),
      .short_q    (short_q)
   );

   assign ch_en      = part & {NUM_CH{~fault_clr}};
   assign open_flag  = open_q;
   assign short_flag = short_q;
   assign led_fault  = (|open_q | |short_q) & ~fault_clr;

endmodule

// File: rtl/hr_ctrl_chk.sv
// Property checker for hr_ctrl.
module hr_ctrl_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              normal_en,
   input logic              eval_tick,
   input logic              fault_clr,
   input logic [NUM_CH-1:0] gnd_mask,
   input logic [CODE_W-1:0] vtgt_code,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] open_flag,
   input logic [NUM_CH-1:0] short_flag,
   input logic              led_fault
);

   localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

   // R10: idle cycles leave the code alone
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_tick |=> $stable(vtgt_code));

   // R1 / R2: one LSB at most per tick
   a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick |=> ({1'b0, vtgt_code} == {1'b0, $past(vtgt_code)}) ||
                    ({1'b0, vtgt_code} == {1'b0, $past(vtgt_code)} + 1'b1) ||
                    ({1'b0, vtgt_code} + 1'b1 == {1'b0, $past(vtgt_code)}));

   // R8: no wrap from full scale to zero
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, $past(vtgt_code)} == FULL) |-> (vtgt_code != '0));

   // R9: clear pulse freezes the code
   a_r9_clear_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> $stable(vtgt_code));

   // R9: outputs off during the clear pulse
   a_r9_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |-> (ch_en == '0) && !led_fault);

   // R4: grounded channels stay disabled
   a_r4_grounded_off: assert property (@(posedge clk) disable iff (!rst_n)
      !normal_en |=> ((ch_en & $past(gnd_mask)) == '0));

   // R5: a new open flag only appears at full scale
   a_r5_open_at_full: assert property (@(posedge clk) disable iff (!rst_n)
      ((open_flag & ~$past(open_flag)) != '0) |-> ({1'b0, $past(vtgt_code)} == FULL));

   // R7: no new fault outside the normal state
   a_r7_quiet_outside_normal: assert property (@(posedge clk) disable iff (!rst_n)
      !normal_en |=> ((open_flag & ~$past(open_flag)) == '0) &&
                     ((short_flag & ~$past(short_flag)) == '0));

   // R5 / R6: a faulted channel is disabled
   a_r6_faulted_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((ch_en & (open_flag | short_flag)) == '0));

endmodule

bind hr_ctrl hr_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .normal_en  (normal_en),
   .eval_tick  (eval_tick),
   .fault_clr  (fault_clr),
   .gnd_mask   (gnd_mask),
   .vtgt_code  (vtgt_code),
   .ch_en      (ch_en),
   .open_flag  (open_flag),
   .short_flag (short_flag),
   .led_fault  (led_fault)
);

// File: tb/hr_ctrl_tb_top.sv
module hr_ctrl_tb_top;

   localparam int N    = 4;
   localparam int W    = 4;
   localparam int MAXC = (1 << W) - 1;
   localparam int INIT = (MAXC * 88) / 100;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         normal_en = 1'b0;
   logic         eval_tick = 1'b0;
   logic         fault_clr = 1'b0;
   logic [N-1:0] gnd_mask = '0;
   logic [N-1:0] below_low = '0;
   logic [N-1:0] above_band = '0;
   logic [N-1:0] above_mid = '0;
   logic [N-1:0] above_high = '0;
   logic [W-1:0] vtgt_code;
   logic [N-1:0] ch_en;
   logic [N-1:0] open_flag;
   logic [N-1:0] short_flag;
   logic         led_fault;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int           m_code;
   logic [N-1:0] m_gnd, m_op, m_sh;

   always #2.5 clk = ~clk;

   hr_ctrl #(.NUM_CH(N), .CODE_W(W), .INIT_PCT(88)) dut_i (
      .clk(clk), .rst_n(rst_n), .normal_en(normal_en), .eval_tick(eval_tick),
      .fault_clr(fault_clr), .gnd_mask(gnd_mask), .below_low(below_low),
      .above_band(above_band), .above_mid(above_mid), .above_high(above_high),
      .vtgt_code(vtgt_code), .ch_en(ch_en), .open_flag(open_flag),
      .short_flag(short_flag), .led_fault(led_fault)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // state: 0 starved, 1 at threshold, 2 above band, 3 above high
   task automatic set_ch(input int c, input int st);
      below_low[c]  = (st == 0);
      above_band[c] = (st >= 2);
      above_mid[c]  = (st == 3);
      above_high[c] = (st == 3);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0; normal_en = 1'b0; eval_tick = 1'b0; fault_clr = 1'b0;
      gnd_mask = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_code = INIT; m_gnd = '0; m_op = '0; m_sh = '0;
      @(negedge clk);
   endtask

   task automatic check_outs(input string rq);
      logic [N-1:0] part;
      part = ~m_gnd & ~m_op & ~m_sh;
      chk(vtgt_code == W'(m_code), {rq, " code"}, int'(vtgt_code), m_code);
      chk(open_flag == m_op, {rq, " open"}, int'(open_flag), int'(m_op));
      chk(short_flag == m_sh, {rq, " short"}, int'(short_flag), int'(m_sh));
      chk(ch_en == part, {rq, " ch_en"}, int'(ch_en), int'(part));
      chk(led_fault == (|(m_op | m_sh)), {rq, " led_fault"}, int'(led_fault), int'(|(m_op | m_sh)));
   endtask

   // one tick, model updated from the requirements
   task automatic tick_chk(input string rq);
      logic [N-1:0] part, win, nop, nsh;
      bit up, down;
      if (!normal_en) m_gnd = gnd_mask;
      part = ~m_gnd & ~m_op & ~m_sh;
      up   = |(part & below_low);
      down = (part != '0) && ((part & ~(above_band & ~below_low)) == '0);
      nop = '0; nsh = '0;
      if (normal_en) begin
         win = part & ~below_low & ~above_mid;
         for (int c = 0; c < N; c++) begin
            logic [N-1:0] peers;
            peers = win; peers[c] = 1'b0;
            nop[c] = part[c] & below_low[c] & (m_code == MAXC);
            nsh[c] = part[c] & above_high[c] & (|peers);
         end
      end
      if (up) m_code = (m_code == MAXC) ? MAXC : m_code + 1;
      else if (down) m_code = (m_code == 0) ? 0 : m_code - 1;
      m_op = m_op | nop;
      m_sh = m_sh | nsh;
      eval_tick = 1'b1;
      @(negedge clk);
      eval_tick = 1'b0;
      check_outs(rq);
   endtask

   initial begin
      #900000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < N; c++) set_ch(c, 1);
      do_reset();
      // R8 reset state
      check_outs("R8 reset");

      // R1 R2 R3: sweep all three-state combinations
      for (int s = 0; s < 81; s++) begin
         int v;
         v = s;
         for (int c = 0; c < N; c++) begin
            set_ch(c, v % 3);
            v = v / 3;
         end
         tick_chk("R1/R2/R3 sweep");
      end

      // R10: no tick, no change
      for (int c = 0; c < N; c++) set_ch(c, 0);
      repeat (4) @(negedge clk);
      check_outs("R10 idle");

      // R4: ground masks, grounded channels starved, the rest roomy
      for (int m = 0; m < 16; m++) begin
         gnd_mask = N'(m);
         for (int c = 0; c < N; c++) set_ch(c, gnd_mask[c] ? 0 : 2);
         @(negedge clk);
         m_gnd = gnd_mask;
         check_outs("R4 mask");
         tick_chk("R4 mask tick");
      end

      // R5 R7: open detection
      do_reset();
      for (int c = 0; c < N; c++) set_ch(c, 0);
      for (int k = 0; k < 4; k++) tick_chk("R8 saturate high");
      tick_chk("R7 no open outside normal");
      normal_en = 1'b1;
      for (int c = 0; c < N; c++) set_ch(c, 1);
      set_ch(2, 0);
      @(negedge clk);
      tick_chk("R5 open ch2");
      chk(open_flag == 4'b0100, "R5 open flag", int'(open_flag), 4);
      tick_chk("R7 others hold");
      chk(ch_en == 4'b1011, "R7 others enabled", int'(ch_en), 11);

      // R6: short with and without a window companion
      set_ch(0, 3); set_ch(1, 1); set_ch(3, 2);
      tick_chk("R6 short ch0");
      chk(short_flag == 4'b0001, "R6 short flag", int'(short_flag), 1);
      set_ch(1, 3); set_ch(3, 3);
      tick_chk("R6 no companion");
      chk(short_flag == 4'b0001, "R6 no new short", int'(short_flag), 1);

      // R9: clear pulse
      @(negedge clk);
      fault_clr = 1'b1;
      #1;
      chk(ch_en == '0, "R9 enables off", int'(ch_en), 0);
      chk(led_fault == 1'b0, "R9 fault low", int'(led_fault), 0);
      @(negedge clk);
      eval_tick = 1'b1;
      @(negedge clk);
      eval_tick = 1'b0;
      @(negedge clk);
      chk(vtgt_code == W'(m_code), "R9 code frozen", int'(vtgt_code), m_code);
      chk(open_flag == '0 && short_flag == '0, "R9 flags cleared",
          int'({open_flag, short_flag}), 0);
      fault_clr = 1'b0;
      m_op = '0; m_sh = '0;
      @(negedge clk);
      check_outs("R9 after release");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule